// File: doc/BRIEF.md
# Paired-Word Load/Store Sequencer

This block carries out double-word register transfers as two single-word beats on a simple request/ready memory port. A caller pulses a start strobe with a direction select, a base value, a signed 16-bit displacement and an even register number. For a store it also supplies the contents of that register and of the register one above it. The sequencer forms a word-aligned effective address, issues the two beats in a fixed order, and, for loads, emits one register write request per returned word.

The even register and its odd partner are laid out in memory in a crosswise way. The odd partner lives at the aligned address and the even register lives at the word above it. A load reads the lower word first. A store writes the upper word first. A caller with no base register asserts a select that replaces the base value with zero. If the register number is odd, the sequencer refuses the operation without touching memory.

Top module: `dseq_top`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o`, `err_o`, `mem_req_o` and `rf_we_o` are all low.
- R2: The effective address is the base plus the 16-bit displacement sign-extended to 32 bits, with bits [1:0] cleared. The upper beat address is that value plus 4, modulo 2^32. Every beat address therefore has bits [1:0] equal to zero.
- R3: When `no_base_i` is 1 at start, the base value is treated as zero and `base_i` has no effect on the address.
- R4: A load reads the aligned address first and writes that word to register `reg_i+1`. It then reads aligned+4 and writes that word to register `reg_i`.
- R5: A store first writes `wdata_even_i` (the data of `reg_i`) to aligned+4. It then writes `wdata_odd_i` (the data of `reg_i+1`) to the aligned address. `mem_we_o` is 1 on store beats and 0 on load beats.
- R6: If the register number is odd (bit 0 = 1), `err_o` and `done_o` are both high in the cycle after the start. No beat is requested, and no register write is made.
- R7: A beat request keeps its address, write flag and write data steady until `mem_ready_i` is seen high together with `mem_req_o`. Only that handshake advances to the next beat.
- R8: `done_o` is high for exactly one cycle, and that cycle directly follows the second handshake. `busy_o` is high from the cycle after the start through the done cycle, and low afterwards. `err_o` is low on a successful operation.
- R9: A start pulse that arrives while `busy_o` is high is ignored.
- R10: A reset during an operation abandons it. In the next cycle the block is idle with no request, and no done pulse follows.
- R11: Each load handshake is followed one cycle later by a single-cycle `rf_we_o`, with the register index and the returned word. Stores never raise `rf_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| is_store_i | input | 1 | 1 = store, 0 = load |
| no_base_i | input | 1 | 1 = use zero as the base |
| base_i | input | 32 | Base value |
| ofs_i | input | 16 | Signed displacement |
| reg_i | input | 5 | Even register number of the pair |
| wdata_even_i | input | 32 | Store data of register `reg_i` |
| wdata_odd_i | input | 32 | Store data of register `reg_i+1` |
| mem_req_o | output | 1 | Beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 32 | Beat word address |
| mem_wdata_o | output | 32 | Beat write data |
| mem_ready_i | input | 1 | Memory accepts or completes the beat |
| mem_rdata_i | input | 32 | Read data, valid with ready on a read beat |
| rf_we_o | output | 1 | Register write request |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejected operation, high together with done |

## Verification
A wrong beat-order or half-select state appears at the first request as a swapped address (aligned versus aligned+4). For loads, it also appears one cycle after each handshake as a swapped register index. A stuck or skipped sequencing state shows as a third request, a missing second request, or a done pulse that is not exactly one cycle after the last handshake. A stale captured operand shows up when a start arrives during a busy period, because the beats then change address or direction mid-operation.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2,
        ST_FIN   = 2'd3
    } dseq_state_e;

    // The upper word (aligned+WORD) always holds the even register,
    // the lower word its odd partner. Loads visit low then high;
    // stores visit high then low.
    function automatic logic beat_is_upper(input logic is_store, input logic second_beat);
        return is_store ^ second_beat;
    endfunction

endpackage

// File: rtl/dseq_agen.sv
module dseq_agen #(
    parameter int ADDR_W  = 32,
    parameter int OFS_W   = 16,
    parameter int ALIGN_W = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              no_base_i,
    output logic [ADDR_W-1:0] ea_o
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        base_eff = no_base_i ? '0 : base_i;
        ofs_ext  = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
        sum      = base_eff + ofs_ext;
        ea_o     = {sum[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end
endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
    import dseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic odd_reg_i,
    input  logic mem_ready_i,
    output logic accept_o,
    output logic req_o,
    output logic second_o,
    output logic hs_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);
    dseq_state_e state_q, state_d;
    logic        err_q, err_d;

    always_comb begin
        accept_o = start_i && (state_q == ST_IDLE);
        req_o    = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
        second_o = (state_q == ST_BEAT1);
        hs_o     = req_o && mem_ready_i;
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_FIN);
        err_o    = done_o && err_q;
    end

    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o) begin
                    err_d   = odd_reg_i;
                    state_d = odd_reg_i ? ST_FIN : ST_BEAT0;
                end
            end
            ST_BEAT0: if (mem_ready_i) state_d = ST_BEAT1;
            ST_BEAT1: if (mem_ready_i) state_d = ST_FIN;
            ST_FIN: begin
                state_d = ST_IDLE;
                err_d   = 1'b0;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end
endmodule

// File: rtl/dseq_beat.sv
module dseq_beat
    import dseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int REG_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic              is_store_i,
    input  logic              second_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [DATA_W-1:0] d_even_i,
    input  logic [DATA_W-1:0] d_odd_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [REG_W-1:0]  ridx_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic upper;

    always_comb begin
        upper   = beat_is_upper(is_store_i, second_i);
        addr_o  = upper ? (ea_i + STEP) : ea_i;
        wdata_o = upper ? d_even_i : d_odd_i;
        ridx_o  = upper ? reg_i : (reg_i | REG_W'(1));
    end
endmodule

// File: rtl/dseq_top.sv
module dseq_top
    import dseq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int OFS_W      = 16,
    parameter int REG_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              is_store_i,
    input  logic              no_base_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [DATA_W-1:0] wdata_even_i,
    input  logic [DATA_W-1:0] wdata_odd_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              rf_we_o,
    output logic [REG_W-1:0]  rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int ALIGN_W = $clog2(WORD_BYTES);

    logic              accept, second, hs;
    logic [ADDR_W-1:0] ea_comb;
    logic [REG_W-1:0]  beat_ridx;

    logic              is_store_q;
    logic [ADDR_W-1:0] ea_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] d_even_q, d_odd_q;

    dseq_agen #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .ALIGN_W(ALIGN_W)
    ) u_agen (
        .base_i   (base_i),
        .ofs_i    (ofs_i),
        .no_base_i(no_base_i),
        .ea_o     (ea_comb)
    );

    dseq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .odd_reg_i  (reg_i[0]),
        .mem_ready_i(mem_ready_i),
        .accept_o   (accept),
        .req_o      (mem_req_o),
        .second_o   (second),
        .hs_o       (hs),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            is_store_q <= 1'b0;
            ea_q       <= '0;
            reg_q      <= '0;
            d_even_q   <= '0;
            d_odd_q    <= '0;
        end else if (accept) begin
            is_store_q <= is_store_i;
            ea_q       <= ea_comb;
            reg_q      <= reg_i;
            d_even_q   <= wdata_even_i;
            d_odd_q    <= wdata_odd_i;
        end
    end

    dseq_beat #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .REG_W     (REG_W),
        .WORD_BYTES(WORD_BYTES)
    ) u_beat (
        .is_store_i(is_store_q),
        .second_i  (second),
        .ea_i      (ea_q),
        .reg_i     (reg_q),
        .d_even_i  (d_even_q),
        .d_odd_i   (d_odd_q),
        .addr_o    (mem_addr_o),
        .wdata_o   (mem_wdata_o),
        .ridx_o    (beat_ridx)
    );

    assign mem_we_o = is_store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_we_o    <= 1'b0;
            rf_waddr_o <= '0;
            rf_wdata_o <= '0;
        end else begin
            rf_we_o <= hs && !is_store_q;
            if (hs && !is_store_q) begin
                rf_waddr_o <= beat_ridx;
                rf_wdata_o <= mem_rdata_i;
            end
        end
    end
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int AB = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          rf_we
);
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !mem_req && !done && !rf_we));

    p_addr_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[AB-1:0] == '0));

    p_err_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    p_err_no_beat_r6: assert property (@(posedge clk) disable iff (rst)
        err |-> !$past(mem_req));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_rf_after_read_r11: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> $past(mem_req && mem_ready && !mem_we));
endmodule

bind dseq_top dseq_chk #(
    .AW(ADDR_W),
    .DW(DATA_W),
    .AB(ALIGN_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy_o),
    .done     (done_o),
    .err      (err_o),
    .mem_req  (mem_req_o),
    .mem_we   (mem_we_o),
    .mem_ready(mem_ready_i),
    .mem_addr (mem_addr_o),
    .mem_wdata(mem_wdata_o),
    .rf_we    (rf_we_o)
);

// File: tb/sim_dseq_top.sv
module sim_dseq_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, is_store = 1'b0, no_base = 1'b0;
    logic [31:0] base = '0, wd_even = '0, wd_odd = '0;
    logic [15:0] ofs = '0;
    logic [4:0]  regn = '0;
    logic        mem_req, mem_we, mem_ready, rf_we, busy, done, err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_wdata;
    logic [4:0]  rf_waddr;

    int nchk = 0, nfail = 0, lat = 0, cyc = 0, wcnt = 0;
    int nb = 0, nw = 0;
    logic [31:0] b_addr [64];
    logic [31:0] b_data [64];
    logic        b_we   [64];
    int          b_cyc  [64];
    logic [4:0]  w_idx  [64];
    logic [31:0] w_data [64];
    int          w_cyc  [64];
    logic [31:0] mem_arr [64];
    bit          mvalid  [64];
    bit          summary_done = 0;

    dseq_top u0 (
        .clk(clk), .rst(rst), .start_i(start), .is_store_i(is_store),
        .no_base_i(no_base), .base_i(base), .ofs_i(ofs), .reg_i(regn),
        .wdata_even_i(wd_even), .wdata_odd_i(wd_odd),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
        .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'hA5C3_0000;
    endfunction

    assign mem_rdata = mvalid[mem_addr[7:2]] ? mem_arr[mem_addr[7:2]] : pat(mem_addr);
    assign mem_ready = mem_req && (wcnt >= lat);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && !mem_ready) wcnt <= wcnt + 1; else wcnt <= 0;
        if (!rst && mem_req && mem_ready) begin
            b_addr[nb] <= mem_addr;
            b_we[nb]   <= mem_we;
            b_data[nb] <= mem_we ? mem_wdata : mem_rdata;
            b_cyc[nb]  <= cyc;
            nb <= nb + 1;
            if (mem_we) begin
                mem_arr[mem_addr[7:2]] <= mem_wdata;
                mvalid[mem_addr[7:2]]  <= 1'b1;
            end
        end
        if (rf_we) begin
            w_idx[nw]  <= rf_waddr;
            w_data[nw] <= rf_wdata;
            w_cyc[nw]  <= cyc;
            nw <= nw + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ea(input logic nob, input logic [31:0] b, input logic [15:0] o);
        logic [31:0] s;
        s = (nob ? 32'h0 : b) + {{16{o[15]}}, o};
        return {s[31:2], 2'b00};
    endfunction

    task automatic launch(input logic st, input logic nob, input logic [31:0] b,
                          input logic [15:0] o, input logic [4:0] r,
                          input logic [31:0] de, input logic [31:0] dd);
        @(negedge clk);
        is_store = st; no_base = nob; base = b; ofs = o; regn = r;
        wd_even = de; wd_odd = dd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // waits for done after launch; checks busy span, pulse width, timing (R8)
    task automatic finish_op(input string tag);
        int dcyc = -1;
        bit busy_ok = 1;
        for (int i = 0; i < 200; i++) begin
            if (!busy) busy_ok = 0;
            if (done) begin dcyc = cyc; break; end
            @(negedge clk);
        end
        chk(dcyc >= 0, {tag, " R8 done seen"}, 0, 1);
        chk(busy_ok, {tag, " R8 busy held until done"}, busy_ok, 1);
        chk(!err, {tag, " R8 no err on success"}, err, 0);
        chk(dcyc == b_cyc[nb-1] + 1, {tag, " R8 done one cycle after last handshake"}, dcyc, b_cyc[nb-1] + 1);
        @(negedge clk);
        chk(!done && !busy, {tag, " R8 done single cycle, busy drops"}, {done, busy}, 0);
    endtask

    task automatic check_load(input string tag, input int nb0, input int nw0,
                              input logic [31:0] a, input logic [4:0] r,
                              input logic [31:0] exp_lo, input logic [31:0] exp_hi);
        chk(nb == nb0 + 2, {tag, " R4 two beats"}, nb - nb0, 2);
        chk(b_addr[nb0] == a && !b_we[nb0], {tag, " R4 first beat aligned read"}, b_addr[nb0], a);
        chk(b_addr[nb0+1] == a + 4 && !b_we[nb0+1], {tag, " R4 second beat upper read"}, b_addr[nb0+1], a + 4);
        chk(nw == nw0 + 2, {tag, " R11 two register writes"}, nw - nw0, 2);
        chk(w_idx[nw0] == r + 5'd1 && w_data[nw0] == exp_lo, {tag, " R4 odd partner gets lower word"}, w_data[nw0], exp_lo);
        chk(w_idx[nw0+1] == r && w_data[nw0+1] == exp_hi, {tag, " R4 even reg gets upper word"}, w_data[nw0+1], exp_hi);
        chk(w_cyc[nw0] == b_cyc[nb0] + 1 && w_cyc[nw0+1] == b_cyc[nb0+1] + 1,
            {tag, " R11 write one cycle after handshake"}, w_cyc[nw0], b_cyc[nb0] + 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !err && !mem_req && !rf_we, "R1 idle after reset",
            {busy, done, err, mem_req, rf_we}, 0);
    endtask

    task automatic t_load_basic();
        int nb0 = nb, nw0 = nw;
        logic [31:0] a = ea(0, 32'h40, 16'h10);
        lat = 0;
        launch(0, 0, 32'h40, 16'h10, 5'd4, 0, 0);
        finish_op("load_basic");
        check_load("load_basic", nb0, nw0, a, 5'd4, pat(a), pat(a + 4));
    endtask

    task automatic t_load_neg_slow();
        int nb0 = nb, nw0 = nw;
        logic [31:0] a = ea(0, 32'h103, 16'hFFFA);
        lat = 3;
        launch(0, 0, 32'h103, 16'hFFFA, 5'd10, 0, 0);
        finish_op("load_neg");
        chk(a == 32'hFC, "R2 negative offset masked address", a, 32'hFC);
        check_load("load_neg R2 R7", nb0, nw0, 32'hFC, 5'd10, pat(32'hFC), pat(32'h100));
    endtask

    task automatic t_store_then_load();
        int nb0 = nb, nw0 = nw;
        lat = 1;
        launch(1, 0, 32'h21, 16'h0005, 5'd6, 32'hEEEE_0006, 32'h0DD0_0007);
        finish_op("store");
        chk(nb == nb0 + 2, "R5 store two beats", nb - nb0, 2);
        chk(b_we[nb0] && b_addr[nb0] == 32'h28 && b_data[nb0] == 32'hEEEE_0006,
            "R5 first store beat even reg to upper word", b_addr[nb0], 32'h28);
        chk(b_we[nb0+1] && b_addr[nb0+1] == 32'h24 && b_data[nb0+1] == 32'h0DD0_0007,
            "R5 second store beat odd reg to aligned word", b_addr[nb0+1], 32'h24);
        chk(nw == nw0, "R11 store makes no register write", nw - nw0, 0);
        nb0 = nb; nw0 = nw;
        lat = 0;
        launch(0, 0, 32'h24, 16'h0, 5'd12, 0, 0);
        finish_op("reload");
        check_load("reload R4 R5", nb0, nw0, 32'h24, 5'd12, 32'h0DD0_0007, 32'hEEEE_0006);
    endtask

    task automatic t_no_base();
        int nb0 = nb, nw0 = nw;
        lat = 0;
        launch(0, 1, 32'hFFFF_0000, 16'h0032, 5'd0, 0, 0);
        finish_op("nobase");
        chk(b_addr[nb0] == 32'h30, "R3 zero base used", b_addr[nb0], 32'h30);
        check_load("nobase R3", nb0, nw0, 32'h30, 5'd0, pat(32'h30), pat(32'h34));
    endtask

    task automatic t_wrap();
        int nb0 = nb, nw0 = nw;
        lat = 2;
        launch(0, 0, 32'hFFFF_FFFE, 16'h0001, 5'd30, 0, 0);
        finish_op("wrap");
        check_load("wrap R2", nb0, nw0, 32'hFFFF_FFFC, 5'd30, pat(32'hFFFF_FFFC), pat(32'h0));
    endtask

    task automatic t_odd_reg();
        int nb0 = nb, nw0 = nw;
        launch(0, 0, 32'h40, 16'h0, 5'd5, 0, 0);
        chk(done && err && busy && !mem_req, "R6 err with done after start",
            {done, err, busy, mem_req}, 4'b1110);
        @(negedge clk);
        chk(!done && !err && !busy, "R6 back to idle", {done, err, busy}, 0);
        repeat (2) @(negedge clk);
        chk(nb == nb0 && nw == nw0, "R6 no beat and no register write", nb - nb0, 0);
    endtask

    task automatic t_busy_ignore();
        int nb0 = nb, nw0 = nw;
        lat = 4;
        launch(0, 0, 32'h80, 16'h0, 5'd2, 0, 0);
        @(negedge clk);
        is_store = 1; regn = 5'd8; base = 32'h10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_op("ignore");
        repeat (4) @(negedge clk);
        chk(nb == nb0 + 2 && !busy, "R9 start during busy ignored", nb - nb0, 2);
        chk(!b_we[nb0+1] && b_addr[nb0+1] == 32'h84, "R9 second beat unchanged", b_addr[nb0+1], 32'h84);
        check_load("ignore R9", nb0, nw0, 32'h80, 5'd2, pat(32'h80), pat(32'h84));
    endtask

    task automatic t_reset_mid();
        int nb0 = nb;
        bit saw_done = 0;
        lat = 10;
        launch(1, 0, 32'h90, 16'h0, 5'd14, 32'h1, 32'h2);
        repeat (2) @(negedge clk);
        chk(mem_req && nb == nb0, "R7 request held while not ready", mem_req, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !mem_req && !done, "R10 idle after reset mid-op", {busy, mem_req, done}, 0);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (done || mem_req) saw_done = 1;
        end
        chk(!saw_done && nb == nb0, "R10 no done and no beat after abort", nb - nb0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!summary_done) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load_basic();
        t_load_neg_slow();
        t_store_then_load();
        t_no_base();
        t_wrap();
        t_odd_reg();
        t_busy_ignore();
        t_reset_mid();
        summary_done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule